// File: doc/BRIEF.md
# DTMF Receive Timing Qualifier

This block follows a tone detector that reports, once per millisecond tick, a raw "dual tone present" flag and a 4-bit decoded key value. It decides which of those raw reports count as real key presses and presents each accepted key to a host as a stable 4-bit code. A strobe follows the code a few clock cycles later, and the host latches the code on the rising edge of that strobe. A bad report is one that is too short, one that is broken by a long dropout, or one whose key value changes in the middle of a press.

Timing is measured in millisecond ticks. Qualification counts elapsed ticks from the first tick that sees a tone. Dropouts shorter than a pre-strobe bridging window are absorbed, and a dropout that reaches the window abandons the attempt. Once the strobe is high, only a sustained quiet period releases the strobe and the code, so any shorter dropout is absorbed. A select input switches every window between a normal profile and a faster profile.

The window defaults in ticks are:

| Window | Normal | Fast |
|---|---|---|
| Accept | 41 | 26 |
| Bridging | 6 | 4 |
| Release | 28 | 20 |

The strobe delay, in clock cycles, is a parameter.

Top module: `dtmf_rx_qual`

## Requirements
- R1: A synchronous active-high reset drives `rx_strobe` to 0 and `rx_code` to 4'h0. Both stay there until a press is accepted.
- R2: With `fast_sel`=0, a press is accepted on the 41st elapsed tick, provided that tick sees a tone. `rx_code` takes the key value on the clock edge that samples that tick.
- R3: A press that ends, or is abandoned, before it is accepted leaves `rx_code` and `rx_strobe` unchanged. In normal mode any press of 40 or fewer ticks is one such case, and a 23-tick press is another.
- R4: With `fast_sel`=1, the accept count is 26 ticks. A 25-tick press is ignored.
- R5: Before acceptance, a run of toneless ticks shorter than the bridging window (6 normal, 4 fast) keeps qualification alive, and those ticks still count as elapsed. A run that reaches the window returns the block to idle without output.
- R6: After the strobe rises, the release count is 28 consecutive toneless ticks (20 fast). On that tick, `rx_strobe` falls and `rx_code` returns to 4'h0 together.
- R7: While the strobe is high, a run of toneless ticks shorter than the release count does not clear `rx_strobe` or `rx_code`. A tone tick restarts the quiet count.
- R8: The reported key is the value sampled on the first tone tick of a press. Later key values, during qualification or while the strobe is high, do not change `rx_code`.
- R9: `rx_strobe` rises exactly SP_DELAY_CYC clock cycles after `rx_code` is updated, with `rx_code` stable across that rise. Ticks that arrive during this delay are not evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also used for power-down |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| tone_valid | input | 1 | Raw tone-present flag from the detector, sampled on a tick |
| tone_code | input | 4 | Raw decoded key value, sampled on a tick |
| fast_sel | input | 1 | 1 selects the fast timing profile |
| rx_code | output | 4 | Qualified key value, 4'h0 when idle |
| rx_strobe | output | 1 | Key-valid strobe; the host latches `rx_code` on its rising edge |

## Verification
The `rx_code` result is due on the clock edge that samples the accepting or releasing tick. The bench therefore checks it at the falling edge right after each tick pulse. For an acceptance, the bench also samples `rx_strobe` at that falling edge and again SP_DELAY_CYC−1 falling edges later, expecting 0 both times. It expects 1 one falling edge after that, which pins the strobe delay to the exact cycle. Ticks are spaced farther apart than the strobe delay, so every check lands between ticks. The expected values come from a tick-level model that the bench builds from the window counts above.

// File: rtl/dtmf_rx_qual_pkg.sv
package dtmf_rx_qual_pkg;

  typedef enum logic [1:0] {
    QS_IDLE   = 2'd0,
    QS_QUAL   = 2'd1,
    QS_STROBE = 2'd2,
    QS_HOLD   = 2'd3
  } qual_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tdq_windows.sv
module tdq_windows #(
  parameter int CW     = 6,
  parameter int ACC_N  = 41,
  parameter int ACC_F  = 26,
  parameter int BRK_N  = 6,
  parameter int BRK_F  = 4,
  parameter int REL_N  = 28,
  parameter int REL_F  = 20
) (
  input  logic          fast_sel,
  output logic [CW-1:0] acc_lim,
  output logic [CW-1:0] brk_lim,
  output logic [CW-1:0] rel_lim
);

  localparam logic [CW-1:0] ACC_NV = CW'(ACC_N);
  localparam logic [CW-1:0] ACC_FV = CW'(ACC_F);
  localparam logic [CW-1:0] BRK_NV = CW'(BRK_N);
  localparam logic [CW-1:0] BRK_FV = CW'(BRK_F);
  localparam logic [CW-1:0] REL_NV = CW'(REL_N);
  localparam logic [CW-1:0] REL_FV = CW'(REL_F);

  always_comb begin
    if (fast_sel) begin
      acc_lim = ACC_FV;
      brk_lim = BRK_FV;
      rel_lim = REL_FV;
    end else begin
      acc_lim = ACC_NV;
      brk_lim = BRK_NV;
      rel_lim = REL_NV;
    end
  end

endmodule

// File: rtl/tdq_subtick.sv
module tdq_subtick #(
  parameter int DELAY = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);

  localparam int SW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [SW-1:0] LAST = SW'(DELAY - 1);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == LAST);

  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
    run && !done |=> run && (cnt == $past(cnt) + 1'b1)) else $error("subtick step"); // R9

endmodule

// File: rtl/tdq_fsm.sv
module tdq_fsm
  import dtmf_rx_qual_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          valid,
  input  logic [3:0]    key,
  input  logic [CW-1:0] acc_lim,
  input  logic [CW-1:0] brk_lim,
  input  logic [CW-1:0] rel_lim,
  input  logic          delay_done,
  output logic          delay_run,
  output logic [3:0]    code_q,
  output logic          strobe_q
);

  qual_state_t   st;
  logic [CW-1:0] elapsed;
  logic [CW-1:0] gap;
  logic [CW-1:0] quiet;
  logic [3:0]    cand;
  logic [CW-1:0] elapsed_nx;
  logic [CW-1:0] gap_nx;
  logic [CW-1:0] quiet_nx;

  assign elapsed_nx = elapsed + 1'b1;
  assign gap_nx     = gap + 1'b1;
  assign quiet_nx   = quiet + 1'b1;
  assign delay_run  = (st == QS_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= QS_IDLE;
      elapsed  <= '0;
      gap      <= '0;
      quiet    <= '0;
      cand     <= 4'h0;
      code_q   <= 4'h0;
      strobe_q <= 1'b0;
    end else begin
      case (st)
        QS_IDLE: begin
          if (tick && valid) begin
            cand    <= key;
            elapsed <= CW'(1);
            gap     <= '0;
            st      <= QS_QUAL;
          end
        end
        QS_QUAL: begin
          if (tick) begin
            if (valid) begin
              gap <= '0;
              if (elapsed_nx >= acc_lim) begin
                code_q <= cand;
                st     <= QS_STROBE;
              end else begin
                elapsed <= elapsed_nx;
              end
            end else if (gap_nx >= brk_lim) begin
              st <= QS_IDLE;
            end else begin
              gap     <= gap_nx;
              elapsed <= (elapsed_nx >= acc_lim) ? acc_lim : elapsed_nx;
            end
          end
        end
        QS_STROBE: begin
          if (delay_done) begin
            strobe_q <= 1'b1;
            quiet    <= '0;
            st       <= QS_HOLD;
          end
        end
        QS_HOLD: begin
          if (tick) begin
            if (valid) begin
              quiet <= '0;
            end else if (quiet_nx >= rel_lim) begin
              strobe_q <= 1'b0;
              code_q   <= 4'h0;
              st       <= QS_IDLE;
            end else begin
              quiet <= quiet_nx;
            end
          end
        end
        default: st <= QS_IDLE;
      endcase
    end
  end

  AST_GAP_BELOW_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (st == QS_QUAL) |-> (gap < brk_lim)) else $error("gap window"); // R5
  AST_QUIET_BELOW_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (st == QS_HOLD) |-> (quiet < rel_lim)) else $error("quiet window"); // R7
  AST_STROBE_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_q) |-> $stable(code_q)) else $error("code moved at strobe"); // R9
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    strobe_q && $past(strobe_q) |-> $stable(code_q)) else $error("code changed in hold"); // R8
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_q) |-> (code_q == 4'h0)) else $error("release split"); // R6
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == QS_IDLE) |-> !strobe_q) else $error("strobe in idle"); // R3

endmodule

// File: rtl/dtmf_rx_qual.sv
module dtmf_rx_qual
  import dtmf_rx_qual_pkg::*;
#(
  parameter int ACC_N        = 41,
  parameter int ACC_F        = 26,
  parameter int BRK_N        = 6,
  parameter int BRK_F        = 4,
  parameter int REL_N        = 28,
  parameter int REL_F        = 20,
  parameter int SP_DELAY_CYC = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       tone_valid,
  input  logic [3:0] tone_code,
  input  logic       fast_sel,
  output logic [3:0] rx_code,
  output logic       rx_strobe
);

  localparam int MAXLIM = max3(max3(ACC_N, ACC_F, BRK_N), max3(BRK_F, REL_N, REL_F), 2);
  localparam int CW     = $clog2(MAXLIM + 2);

  logic [CW-1:0] acc_lim;
  logic [CW-1:0] brk_lim;
  logic [CW-1:0] rel_lim;
  logic          delay_run;
  logic          delay_done;

  tdq_windows #(
    .CW(CW), .ACC_N(ACC_N), .ACC_F(ACC_F), .BRK_N(BRK_N),
    .BRK_F(BRK_F), .REL_N(REL_N), .REL_F(REL_F)
  ) i_windows (
    .fast_sel (fast_sel),
    .acc_lim  (acc_lim),
    .brk_lim  (brk_lim),
    .rel_lim  (rel_lim)
  );

  tdq_subtick #(.DELAY(SP_DELAY_CYC)) i_subtick (
    .clk  (clk),
    .rst  (rst),
    .run  (delay_run),
    .done (delay_done)
  );

  tdq_fsm #(.CW(CW)) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick       (ms_tick),
    .valid      (tone_valid),
    .key        (tone_code),
    .acc_lim    (acc_lim),
    .brk_lim    (brk_lim),
    .rel_lim    (rel_lim),
    .delay_done (delay_done),
    .delay_run  (delay_run),
    .code_q     (rx_code),
    .strobe_q   (rx_strobe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !rx_strobe && (rx_code == 4'h0)) else $error("reset state"); // R1

endmodule

// File: tb/test_dtmf_rx_qual.sv
module test_dtmf_rx_qual;

  localparam int SPD     = 8;
  localparam int TICKGAP = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b0;
  logic       tone_valid = 1'b0;
  logic [3:0] tone_code = 4'h0;
  logic       fast_sel = 1'b0;
  logic [3:0] rx_code;
  logic       rx_strobe;

  always #2 clk = ~clk;

  dtmf_rx_qual #(.SP_DELAY_CYC(SPD)) i_dtmf_rx_qual (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .tone_valid(tone_valid),
    .tone_code(tone_code), .fast_sel(fast_sel), .rx_code(rx_code), .rx_strobe(rx_strobe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  // tick-level reference: 0 idle, 1 qualifying, 2 holding
  int       m_st = 0;
  int       m_el, m_gap, m_q;
  logic [3:0] m_cand, m_code;
  bit       m_sp;

  function automatic int lim_acc(); return fast_sel ? 26 : 41; endfunction
  function automatic int lim_brk(); return fast_sel ? 4 : 6; endfunction
  function automatic int lim_rel(); return fast_sel ? 20 : 28; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_el = 0; m_gap = 0; m_q = 0; m_cand = 0; m_code = 0; m_sp = 0;
  endtask

  task automatic model_step(input bit p, input logic [3:0] c, output bit accepted);
    accepted = 0;
    case (m_st)
      0: if (p) begin m_cand = c; m_el = 1; m_gap = 0; m_st = 1; end
      1: begin
        m_el++;
        if (p) begin
          m_gap = 0;
          if (m_el >= lim_acc()) begin
            m_code = m_cand; accepted = 1; m_st = 2; m_q = 0;
          end
        end else begin
          m_gap++;
          if (m_gap >= lim_brk()) m_st = 0;
          if (m_el > lim_acc()) m_el = lim_acc();
        end
      end
      default: begin
        if (p) m_q = 0;
        else begin
          m_q++;
          if (m_q >= lim_rel()) begin m_sp = 0; m_code = 0; m_st = 0; end
        end
      end
    endcase
  endtask

  task automatic do_tick(input bit p, input logic [3:0] c, input string req);
    bit acc;
    @(negedge clk);
    ms_tick = 1'b1; tone_valid = p; tone_code = c;
    @(negedge clk);
    ms_tick = 1'b0;
    tone_code = 4'($urandom_range(0, 15));
    model_step(p, c, acc);
    chk(rx_code == m_code, req, rx_code, m_code);
    if (acc) begin
      chk(rx_strobe == 1'b0, "R9 strobe after code", rx_strobe, 0);
      repeat (SPD - 1) @(negedge clk);
      chk(rx_strobe == 1'b0, "R9 strobe early", rx_strobe, 0);
      @(negedge clk);
      chk(rx_strobe == 1'b1, "R9 strobe due", rx_strobe, 1);
      chk(rx_code == m_code, "R9 code stable", rx_code, m_code);
      m_sp = 1;
      repeat (TICKGAP - SPD - 1) @(negedge clk);
    end else begin
      chk(rx_strobe == m_sp, req, rx_strobe, m_sp);
      repeat (TICKGAP - 1) @(negedge clk);
    end
  endtask

  task automatic burst(input bit p, input int n, input logic [3:0] c, input string req);
    for (int i = 0; i < n; i++) do_tick(p, c, req);
  endtask

  task automatic settle();
    burst(0, 32, 4'h0, "R6 settle");
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_code == 4'h0 && !rx_strobe, "R1 reset state", {rx_strobe, rx_code}, 0);

    // R3: 23 and 40 tick presses ignored in normal mode
    burst(1, 23, 4'h5, "R3 short 23"); settle();
    burst(1, 40, 4'h6, "R3 short 40"); settle();
    // R2: exactly 41 ticks accepted, then R6 release at 28 quiet ticks
    burst(1, 41, 4'h7, "R2 accept 41");
    burst(0, 27, 4'h0, "R7 quiet 27 kept");
    burst(0, 1, 4'h0, "R6 release 28");
    settle();
    // R4: fast profile
    fast_sel = 1'b1;
    burst(1, 25, 4'h9, "R4 fast 25 ignored"); settle();
    burst(1, 26, 4'h0, "R4 fast 26 accepted");
    burst(0, 19, 4'h0, "R7 fast quiet 19");
    burst(0, 1, 4'h0, "R6 fast release 20");
    settle();
    fast_sel = 1'b0;
    // R5: dropout of 5 bridged, dropout of 6 abandons
    burst(1, 10, 4'h3, "R5 pre"); burst(0, 5, 4'h0, "R5 bridge 5");
    burst(1, 26, 4'h3, "R5 accept after bridge"); settle();
    burst(1, 10, 4'h4, "R5 pre"); burst(0, 6, 4'h0, "R5 abandon 6");
    burst(1, 35, 4'h4, "R5 restart"); settle();
    // R8: key changes during qualification and hold
    burst(1, 20, 4'hA, "R8 first key"); burst(1, 30, 4'hB, "R8 changed key ignored");
    burst(0, 10, 4'h0, "R7 dropout in hold"); burst(1, 5, 4'hC, "R8 new key in hold");
    settle();
    // R1: reset during hold
    burst(1, 45, 4'hE, "R2 before reset");
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; model_reset();
    chk(rx_code == 4'h0 && !rx_strobe, "R1 reset in hold", {rx_strobe, rx_code}, 0);

    for (int ep = 0; ep < 40; ep++) begin
      fast_sel = 1'($urandom_range(0, 1));
      for (int seg = 0; seg < 6; seg++) begin
        int len;
        bit p;
        p = 1'($urandom_range(0, 3) != 0);
        len = p ? $urandom_range(1, 30) : $urandom_range(1, 8);
        burst(p, len, 4'($urandom_range(0, 15)), "R5 random");
      end
      settle();
    end
    finish_run();
  end

endmodule